// File: doc/BRIEF.md
# NOR Flash Command Interpreter Model

This block is a synthesizable device-side model of a NOR flash part that is driven by unlock-style command sequences. It watches single-cycle write strobes on a shared address/data bus and follows the host through the two unlock writes and the command byte that comes after them. From there it enters one of four behaviours: plain array reads, identification reads, a program operation, or a sector or whole-array erase. The storage is a small register array split into equal sectors.

While a program or erase runs, the model holds a busy flag for a fixed number of clocks and answers every read with a polling status word instead of array contents. The polling bit, the toggle bit, the overrun bit and the erase-window bit let a host sequencer wait for completion and detect failure. A test input can force an overrun. The operation then never completes, and the host has to write a reset command to abort it. The model is intended as a self-checking counterpart for a flash command sequencer in simulation or on an emulation platform.

Top module: `nor_cmd_model`

## Requirements
- R1: After reset the model is idle (busy low), in array-read mode, every stored word reads as all ones, and the status toggle bit starts at 0.
- R2: A read strobe captures a result into rdata at that clock edge, and rdata is visible from the next cycle on. In array-read mode the result is the word at index addr[IW-1:0]. rdata holds its value when no read strobe is given.
- R3: A command is accepted only after a write of 0xAA at address 0x5555 followed by a write of 0x55 at 0xAAAA. Any non-matching write while idle cancels the partial sequence and leaves identification mode.
- R4: Unlock followed by 0x90 at 0x5555 enters identification mode. In that mode a read at address 0 returns MANUF_ID, a read at address 1 returns DEVICE_ID and any other address returns 0, as often as the host reads. Unlock followed by 0xF0 at 0x5555 returns to array reads.
- R5: Unlock followed by 0xA0 at 0x5555 makes the next write a program of that data at that address. At completion the stored word becomes the old word ANDed with the data.
- R6: Unlock, 0x80 at 0x5555, then unlock again, then 0x30 at any address erases the sector selected by addr[IW-1:SECW]. Ending the same sequence with 0x10 at 0x5555 erases every word. Erased words read as all ones.
- R7: While busy, a read returns a status word. Bit 7 is the complement of bit 7 of the programmed data (0 for an erase), bit 3 is 1 for an erase and 0 for a program, and bits 4, 2, 1 and 0 are 0.
- R8: Status bit 6 holds the toggle state and inverts after every read taken while busy.
- R9: Writes during a running operation have no effect on the array, on the command sequence or on the mode.
- R10: force_timeout high while busy sets status bit 5 and stops the operation. The model then stays busy until a write with data 0xF0, which ends the operation with the array unchanged.
- R11: busy rises on the cycle after the write that starts an operation and stays high for exactly BUSY_CYCLES cycles when no overrun is forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one bus write per cycle high |
| rd_en | input | 1 | Read strobe, one bus read per cycle high |
| addr | input | AW | Bus address shared by reads and writes |
| wdata | input | DW | Write data or command byte |
| force_timeout | input | 1 | Test input that forces an overrun of the running operation |
| rdata | output | DW | Registered read result: array word, identification code or status |
| busy | output | 1 | High while a program or erase is running |

## Verification
A wrong sequence state shows up at the first read after the command. The model then returns array data where an identification code or a status word was due, or it raises busy for a command that never finished. A stale or miscounted timer shows on the busy pin within BUSY_CYCLES clocks of the starting write. A wrong masking or sector decode stays hidden until the affected word is read back, so the bench reads neighbouring words on both sides of each sector boundary. The bench's reference model compares rdata and busy on every clock, so any divergence is reported in the cycle in which it first appears.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam logic [15:0] ADDR_KEY_A = 16'h5555;
    localparam logic [15:0] ADDR_KEY_B = 16'hAAAA;

    localparam logic [7:0] CODE_KEY_A   = 8'hAA;
    localparam logic [7:0] CODE_KEY_B   = 8'h55;
    localparam logic [7:0] CODE_IDENT   = 8'h90;
    localparam logic [7:0] CODE_RESET   = 8'hF0;
    localparam logic [7:0] CODE_PROGRAM = 8'hA0;
    localparam logic [7:0] CODE_ERASE   = 8'h80;
    localparam logic [7:0] CODE_SECTOR  = 8'h30;
    localparam logic [7:0] CODE_WHOLE   = 8'h10;

    localparam int ST_POLL   = 7;
    localparam int ST_TOGGLE = 6;
    localparam int ST_LIMIT  = 5;
    localparam int ST_WINDOW = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PGM,
        SQ_ERA0,
        SQ_ERA1,
        SQ_ERA2
    } seq_t;

    typedef enum logic [1:0] {
        OP_PROGRAM,
        OP_SECTOR,
        OP_WHOLE
    } op_t;

    typedef struct packed {
        seq_t seq;
        logic ident;
    } decode_state_t;

endpackage

// File: rtl/nor_seq_decode.sv
module nor_seq_decode
    import nor_cmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output logic          ident,
    output logic          go_program,
    output logic          go_sector,
    output logic          go_whole
);

    decode_state_t st_d, st_q;

    logic       hit_a, hit_b;
    logic [7:0] code;

    assign hit_a = (addr == AW'(ADDR_KEY_A));
    assign hit_b = (addr == AW'(ADDR_KEY_B));
    assign code  = wdata[7:0];

    always_comb begin
        st_d       = st_q;
        go_program = 1'b0;
        go_sector  = 1'b0;
        go_whole   = 1'b0;
        if (wr_en && !busy) begin
            st_d.seq = SQ_IDLE;
            unique case (st_q.seq)
                SQ_IDLE: begin
                    if (hit_a && code == CODE_KEY_A) st_d.seq = SQ_KEY1;
                    else                             st_d.ident = 1'b0;
                end
                SQ_KEY1: begin
                    if (hit_b && code == CODE_KEY_B) st_d.seq = SQ_KEY2;
                    else                             st_d.ident = 1'b0;
                end
                SQ_KEY2: begin
                    st_d.ident = 1'b0;
                    if (hit_a && code == CODE_IDENT)        st_d.ident = 1'b1;
                    else if (hit_a && code == CODE_PROGRAM) st_d.seq   = SQ_PGM;
                    else if (hit_a && code == CODE_ERASE)   st_d.seq   = SQ_ERA0;
                end
                SQ_PGM:  go_program = 1'b1;
                SQ_ERA0: if (hit_a && code == CODE_KEY_A) st_d.seq = SQ_ERA1;
                SQ_ERA1: if (hit_b && code == CODE_KEY_B) st_d.seq = SQ_ERA2;
                SQ_ERA2: begin
                    if (code == CODE_SECTOR)               go_sector = 1'b1;
                    else if (hit_a && code == CODE_WHOLE)  go_whole  = 1'b1;
                end
                default: st_d.seq = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.seq   <= SQ_IDLE;
            st_q.ident <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ident = st_q.ident;

    // R3: a single write can start at most one operation
    a_r3_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_program, go_sector, go_whole}));

    // R9: the mode is frozen while an operation runs
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.ident));

    // R9: the sequence does not advance while an operation runs
    a_r9_seq_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.seq));

endmodule

// File: rtl/nor_op_ctrl.sv
module nor_op_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int DW          = 8,
    parameter int IW          = 4,
    parameter int BUSY_CYCLES = 8,
    localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    input  logic          force_timeout,
    input  logic          go_program,
    input  logic          go_sector,
    input  logic          go_whole,
    output logic          busy,
    output logic          timed_out,
    output op_t           op,
    output logic [IW-1:0] tgt_idx,
    output logic [DW-1:0] tgt_data,
    output logic          commit
);

    typedef struct packed {
        logic          busy;
        logic          timed_out;
        logic [CW-1:0] cnt;
        op_t           op;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (st_q.busy) begin
            if (st_q.timed_out) begin
                if (wr_en && wdata[7:0] == CODE_RESET) begin
                    st_d.busy      = 1'b0;
                    st_d.timed_out = 1'b0;
                end
            end else if (force_timeout) begin
                st_d.timed_out = 1'b1;
            end else if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                commit    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end else if (go_program || go_sector || go_whole) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(BUSY_CYCLES);
            st_d.idx  = idx;
            st_d.data = wdata;
            if (go_program)     st_d.op = OP_PROGRAM;
            else if (go_sector) st_d.op = OP_SECTOR;
            else                st_d.op = OP_WHOLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy      <= 1'b0;
            st_q.timed_out <= 1'b0;
            st_q.cnt       <= '0;
            st_q.op        <= OP_PROGRAM;
            st_q.idx       <= '0;
            st_q.data      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign timed_out = st_q.timed_out;
    assign op        = st_q.op;
    assign tgt_idx   = st_q.idx;
    assign tgt_data  = st_q.data;

    // R11: a new operation starts with the full busy window loaded
    a_r11_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> st_q.cnt == CW'(BUSY_CYCLES));

    // R11: the remaining count never leaves the legal range while busy
    a_r11_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt != '0 && st_q.cnt <= CW'(BUSY_CYCLES)));

    // R11: an undisturbed operation counts down one step per clock
    a_r11_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !st_q.timed_out && !force_timeout && st_q.cnt != CW'(1))
        |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - CW'(1)));

    // R10: an overrun operation stays stuck until the reset code is written
    a_r10_stuck: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.timed_out && !(wr_en && wdata[7:0] == CODE_RESET))
        |=> (st_q.busy && st_q.timed_out));

endmodule

// File: rtl/nor_flash_array.sv
module nor_flash_array
    import nor_cmd_pkg::*;
#(
    parameter int DW           = 8,
    parameter int WORDS        = 16,
    parameter int SECTOR_WORDS = 4,
    localparam int IW          = $clog2(WORDS),
    localparam int SECW        = $clog2(SECTOR_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  op_t           op,
    input  logic [IW-1:0] tgt_idx,
    input  logic [DW-1:0] tgt_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_word
);

    logic [WORDS-1:0][DW-1:0] mem_d, mem_q;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam int SEC = g / SECTOR_WORDS;
        logic own_word, own_sector;

        assign own_word   = (tgt_idx == IW'(g));
        assign own_sector = (tgt_idx[IW-1:SECW] == SEC[IW-SECW-1:0]);

        always_comb begin
            mem_d[g] = mem_q[g];
            if (commit) begin
                unique case (op)
                    OP_PROGRAM: if (own_word)   mem_d[g] = mem_q[g] & tgt_data;
                    OP_SECTOR:  if (own_sector) mem_d[g] = '1;
                    OP_WHOLE:                   mem_d[g] = '1;
                    default:                    mem_d[g] = mem_q[g];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign rd_word = mem_q[rd_idx];

    // R9: contents change only when an operation completes
    a_r9_array_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mem_q));

    // R5: a program can only clear bits, never set them
    a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_PROGRAM) |=> ((mem_q & ~$past(mem_q)) == '0));

endmodule

// File: rtl/nor_cmd_model.sv
module nor_cmd_model
    import nor_cmd_pkg::*;
#(
    parameter int          AW           = 16,
    parameter int          DW           = 8,
    parameter int          WORDS        = 16,
    parameter int          SECTOR_WORDS = 4,
    parameter int          BUSY_CYCLES  = 8,
    parameter logic [7:0]  MANUF_ID     = 8'h01,
    parameter logic [7:0]  DEVICE_ID    = 8'h7E,
    localparam int         IW           = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          force_timeout,
    output logic [DW-1:0] rdata,
    output logic          busy
);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          toggle;
    } read_state_t;

    read_state_t rs_d, rs_q;

    logic          ident, go_program, go_sector, go_whole;
    logic          timed_out, commit;
    op_t           op;
    logic [IW-1:0] tgt_idx;
    logic [DW-1:0] tgt_data, rd_word;

    nor_seq_decode #(.AW(AW), .DW(DW)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .busy       (busy),
        .ident      (ident),
        .go_program (go_program),
        .go_sector  (go_sector),
        .go_whole   (go_whole)
    );

    nor_op_ctrl #(.DW(DW), .IW(IW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .idx           (addr[IW-1:0]),
        .wdata         (wdata),
        .force_timeout (force_timeout),
        .go_program    (go_program),
        .go_sector     (go_sector),
        .go_whole      (go_whole),
        .busy          (busy),
        .timed_out     (timed_out),
        .op            (op),
        .tgt_idx       (tgt_idx),
        .tgt_data      (tgt_data),
        .commit        (commit)
    );

    nor_flash_array #(.DW(DW), .WORDS(WORDS), .SECTOR_WORDS(SECTOR_WORDS)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .op       (op),
        .tgt_idx  (tgt_idx),
        .tgt_data (tgt_data),
        .rd_idx   (addr[IW-1:0]),
        .rd_word  (rd_word)
    );

    always_comb begin
        logic [DW-1:0] status;
        rs_d   = rs_q;
        status = '0;
        if (rd_en) begin
            if (busy) begin
                status[ST_POLL]   = (op == OP_PROGRAM) ? ~tgt_data[ST_POLL] : 1'b0;
                status[ST_TOGGLE] = rs_q.toggle;
                status[ST_LIMIT]  = timed_out;
                status[ST_WINDOW] = (op != OP_PROGRAM);
                rs_d.rdata  = status;
                rs_d.toggle = ~rs_q.toggle;
            end else if (ident) begin
                if (addr == '0)            rs_d.rdata = DW'(MANUF_ID);
                else if (addr == AW'(1))   rs_d.rdata = DW'(DEVICE_ID);
                else                       rs_d.rdata = '0;
            end else begin
                rs_d.rdata = rd_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q.rdata  <= '0;
            rs_q.toggle <= 1'b0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rdata = rs_q.rdata;

    // R2: the read result holds between read strobes
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R8: each status read flips the toggle bit
    a_r8_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rs_q.toggle != $past(rs_q.toggle)));

    // R8: the toggle bit never moves outside a status read
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && busy) |=> $stable(rs_q.toggle));

endmodule

// File: tb/test_nor_cmd_model.sv
module test_nor_cmd_model;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int NW = 16;
    localparam int SW = 4;
    localparam int NB = 8;
    localparam logic [7:0] MAN = 8'h01;
    localparam logic [7:0] DEV = 8'h7E;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          force_timeout = 1'b0;
    logic [DW-1:0] rdata;
    logic          busy;

    nor_cmd_model #(.AW(AW), .DW(DW), .WORDS(NW), .SECTOR_WORDS(SW),
                    .BUSY_CYCLES(NB), .MANUF_ID(MAN), .DEVICE_ID(DEV)) i_nor_cmd_model (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .force_timeout(force_timeout), .rdata(rdata), .busy(busy)
    );

    always #5 clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    string phase = "R1";
    bit    done  = 0;

    task automatic check(string tag, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // ---------------- reference model (behavioural) ----------------
    int unsigned  m_mem[NW];
    logic [31:0]  m_seq[$];
    bit           m_ident, m_busy, m_to, m_tog;
    int           m_cnt, m_op, m_tidx;
    logic [7:0]   m_tdata, m_rd;

    function automatic bit at(logic [31:0] w, int a, int d);
        return (w[31:8] == 24'(a)) && (w[7:0] == 8'(d));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_seq.delete();
            m_ident = 0; m_busy = 0; m_to = 0; m_tog = 0;
            m_cnt = 0; m_op = 0; m_tidx = 0; m_tdata = 0; m_rd = 0;
        end else begin
            if (rd_en) begin
                if (m_busy) begin
                    m_rd = 8'h00;
                    if (m_op == 0) m_rd[7] = ~m_tdata[7];
                    else           m_rd[3] = 1'b1;
                    m_rd[6] = m_tog;
                    m_rd[5] = m_to;
                    m_tog = !m_tog;
                end else if (m_ident) begin
                    m_rd = (addr == 0) ? MAN : (addr == 1) ? DEV : 8'h00;
                end else begin
                    m_rd = 8'(m_mem[addr % NW]);
                end
            end
            if (m_busy) begin
                if (m_to) begin
                    if (wr_en && wdata == 8'hF0) begin m_busy = 0; m_to = 0; end
                end else if (force_timeout) begin
                    m_to = 1;
                end else if (m_cnt == 1) begin
                    m_busy = 0;
                    for (int i = 0; i < NW; i++) begin
                        if (m_op == 0 && i == m_tidx) m_mem[i] = m_mem[i] & m_tdata;
                        if (m_op == 1 && i / SW == m_tidx / SW) m_mem[i] = 8'hFF;
                        if (m_op == 2) m_mem[i] = 8'hFF;
                    end
                end else begin
                    m_cnt--;
                end
            end else if (wr_en) begin
                m_seq.push_back({8'h00, addr, wdata});
                case (m_seq.size())
                    1: if (!at(m_seq[0], 'h5555, 'hAA)) begin m_seq.delete(); m_ident = 0; end
                    2: if (!at(m_seq[1], 'hAAAA, 'h55)) begin m_seq.delete(); m_ident = 0; end
                    3: begin
                        m_ident = at(m_seq[2], 'h5555, 'h90);
                        if (!(at(m_seq[2], 'h5555, 'hA0) || at(m_seq[2], 'h5555, 'h80)))
                            m_seq.delete();
                    end
                    4: begin
                        if (m_seq[2][7:0] == 8'hA0) begin
                            m_busy = 1; m_cnt = NB; m_op = 0;
                            m_tidx = int'(addr) % NW; m_tdata = wdata;
                            m_seq.delete();
                        end else if (!at(m_seq[3], 'h5555, 'hAA)) m_seq.delete();
                    end
                    5: if (!at(m_seq[4], 'hAAAA, 'h55)) m_seq.delete();
                    default: begin
                        if (wdata == 8'h30) begin
                            m_busy = 1; m_cnt = NB; m_op = 1; m_tidx = int'(addr) % NW;
                        end else if (at(m_seq[5], 'h5555, 'h10)) begin
                            m_busy = 1; m_cnt = NB; m_op = 2; m_tidx = 0;
                        end
                        m_seq.delete();
                    end
                endcase
            end
        end
    end

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " busy vs model"}, int'(busy), int'(m_busy));
            check({phase, " rdata vs model"}, int'(rdata), int'(m_rd));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, int d);
        wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [7:0] v);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic unlock();
        wr('h5555, 'hAA);
        wr('hAAAA, 'h55);
    endtask

    task automatic program_word(int a, int d);
        unlock();
        wr('h5555, 'hA0);
        wr(a, d);
    endtask

    task automatic erase_setup();
        unlock();
        wr('h5555, 'h80);
        unlock();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, s1, s2;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        phase = "R1";
        check("R1 busy after reset", int'(busy), 0);
        rd(0, v);  check("R1 word 0 erased", v, 'hFF);
        rd(15, v); check("R1 word 15 erased", v, 'hFF);

        phase = "R5";
        program_word(3, 'h5A);
        check("R11 busy after program start", int'(busy), 1);
        rd(3, s1); check("R7 program status", s1 & 'hBF, 'h80);
        rd(3, s2); check("R8 toggle flips", (s1 ^ s2) & 'hFF, 'h40);
        wait_idle();
        rd(3, v); check("R5 programmed word", v, 'h5A);

        phase = "R11";
        program_word(3, 'h0F);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
        check("R11 busy length", n, NB);
        rd(3, v); check("R5 program ANDs", v, 'h0A);
        rd(2, v); check("R2 neighbour unchanged", v, 'hFF);

        phase = "R4";
        unlock(); wr('h5555, 'h90);
        rd(0, v); check("R4 manufacturer code", v, MAN);
        rd(1, v); check("R4 device code", v, DEV);
        rd(0, v); check("R4 repeat read", v, MAN);
        rd(7, v); check("R4 other offset", v, 0);
        unlock(); wr('h5555, 'hF0);
        rd(3, v); check("R4 exit to array", v, 'h0A);

        phase = "R3";
        unlock(); wr('h5555, 'h90);
        wr('h0000, 'h12);
        rd(0, v); check("R3 stray write leaves ident", v, 'hFF);
        wr('h5555, 'hAA); wr('h1234, 'h55); wr('h5555, 'hA0); wr(4, 'h00);
        check("R3 broken unlock not busy", int'(busy), 0);
        rd(4, v); check("R3 broken unlock no program", v, 'hFF);

        phase = "R6";
        program_word(4, 'h00); wait_idle();
        program_word(8, 'h00); wait_idle();
        erase_setup(); wr('h0005, 'h30);
        rd(4, s1); check("R7 erase status", s1 & 'hBF, 'h08);
        wait_idle();
        rd(4, v); check("R6 sector word 4 erased", v, 'hFF);
        rd(8, v); check("R6 next sector kept", v, 'h00);
        rd(3, v); check("R6 previous sector kept", v, 'h0A);

        phase = "R9";
        program_word(9, 'h00);
        unlock(); wr('h5555, 'hA0); wr(10, 'h00);
        wait_idle();
        check("R9 no second operation", int'(busy), 0);
        rd(10, v); check("R9 busy write ignored", v, 'hFF);
        rd(9, v);  check("R9 first program done", v, 'h00);

        phase = "R10";
        program_word(12, 'h00);
        force_timeout = 1'b1; @(negedge clk); force_timeout = 1'b0;
        rd(12, s1); check("R10 limit bit", s1 & 'h20, 'h20);
        repeat (2 * NB) @(negedge clk);
        check("R10 still busy", int'(busy), 1);
        wr('hAAAA, 'h55);
        check("R10 other write no abort", int'(busy), 1);
        wr('h0000, 'hF0);
        check("R10 reset ends op", int'(busy), 0);
        rd(12, v); check("R10 array unchanged", v, 'hFF);

        phase = "R6";
        erase_setup(); wr('h5555, 'h10);
        wait_idle();
        rd(9, v); check("R6 whole erase word 9", v, 'hFF);
        rd(8, v); check("R6 whole erase word 8", v, 'hFF);
        rd(3, v); check("R6 whole erase word 3", v, 'hFF);

        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule